// File: doc/BRIEF.md
# Shared interrupt pending and enable store with delegated CSR views

This block holds one physical set of interrupt-pending bits and one set of interrupt-enable bits. It presents them through several CSR addresses: machine, supervisor, hypervisor, hypervisor-virtual-injection and guest (virtual-supervisor) windows. Two delegation registers decide which bits each window can see, which bits it can change and, for the guest window, where each bit sits. No window keeps its own copy of a bit. Each one is a masked, and for the guest a shifted, view of the same flops.

A CSR access carries an address, a write flag, write data, the current privilege and a virtualization flag. Read data comes back one cycle later from a register. It shows the value from before any write made by that same access. Hardware interrupt lines feed into the pending value. Every cycle the block also produces three registered vectors of pending-and-enabled interrupts: one for machine level, one for supervisor level and one for the guest. Each is routed by delegation.

Bit positions used throughout: 1 supervisor software, 2 guest software, 3 machine software, 5 supervisor timer, 6 guest timer, 7 machine timer, 9 supervisor external, 10 guest external, 11 machine external. CSR addresses: machine pending 0x344, machine enable 0x304, machine delegation 0x303, supervisor pending 0x144, supervisor enable 0x104, hypervisor pending 0x644, hypervisor enable 0x604, virtual injection 0x645, hypervisor delegation 0x603, guest pending 0x244, guest enable 0x204. Privilege encoding: 3 machine, 1 supervisor, 0 user.

Top module: `intr_view_csr`

## Requirements
- R1: After synchronous reset, both stores and both delegation registers hold zero, read data is zero and all three interrupt vectors are zero. The machine delegation register reads 0x0444.
- R2: Machine delegation (0x303) is writable only at bits 1, 5 and 9. Bits 2, 6 and 10 always read one. All other bits read zero, so writing 0xFFFF reads back 0x0666 and writing 0 reads back 0x0444.
- R3: Hypervisor delegation (0x603) is writable only at bits 2, 6 and 10. All other bits, including the machine bits 3, 7 and 11, read zero.
- R4: The machine pending view (0x344) reads bits 1,2,3,5,6,7,9,10,11 and writes only bits 1, 2, 5 and 9. Hardware lines at bits 3, 7, 9, 10 and 11 are ORed into the pending value, and writes cannot clear them.
- R5: The supervisor pending view (0x144) shows only the bits set in machine delegation. Of those bits, only bit 1 is writable; the timer bit 5 is read-only there.
- R6: The virtual injection register (0x645) reads and writes the stored bits 2, 6 and 10. These are the same bits that the machine view (0x344) and the hypervisor pending view (0x644) show.
- R7: The guest pending view (0x244) shows each guest bit one position lower (10→9, 6→5, 2→1) when its hypervisor delegation bit is one. Otherwise that bit reads zero and ignores writes.
- R8: A guest-view write of bit 1 changes storage bit 2, and the change is visible in the machine and injection views.
- R9: The enable views follow the same masks: machine enable writes all nine bits; supervisor enable is limited to the bits set in machine delegation; hypervisor enable covers bits 2, 6 and 10; guest enable shifts down by one under hypervisor delegation.
- R10: An access below the privilege the address needs (address bits 9:8, where 3 requires machine and 2 requires machine or non-virtualized supervisor) reads zero and writes nothing. A virtualized supervisor access to a 0x1xx address is redirected to the matching 0x2xx guest register.
- R11: Read data appears the cycle after the access and holds the value from before that access's write. It is zero in any cycle that follows no access.
- R12: With p = pending & enable, machine vector = p & ~mdel; supervisor vector = p & mdel & ~hdel; guest vector = (p & hdel & {2,6,10}) shifted down by one. All three are registered.
- R13: An address outside the eleven listed reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | CSR access this cycle |
| csr_we | input | 1 | Access writes |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | DW | Write data |
| csr_priv | input | 2 | Current privilege (3 M, 1 S, 0 U) |
| csr_virt | input | 1 | Hart runs virtualized |
| hw_irq | input | DW | Hardware interrupt lines at bits 3,7,9,10,11 |
| csr_rdata | output | DW | Registered read data |
| m_irq | output | DW | Pending and enabled, machine level |
| s_irq | output | DW | Pending and enabled, supervisor level |
| vs_irq | output | DW | Pending and enabled, guest bit positions |

## Verification
The hardest case is a single stored bit seen through three windows at once: a guest-view write lands one position higher and must show up in the machine and injection views. Reaching it needs a precise order of steps. First, hypervisor delegation is programmed to pass only some guest bits. Next, those bits are loaded through the injection register. Then the guest window is written with all ones and with zero. Finally, the other windows are read back to confirm that undelegated bits were untouched. The stimulus repeats this with delegation cleared, checking that the guest view goes fully dark while the storage keeps its value.

// File: rtl/ipv_pkg.sv
`timescale 1ns/1ps
package ipv_pkg;
  localparam int unsigned ADDR_W = 12;

  // bit positions of the interrupt causes
  localparam int unsigned B_SSW = 1, B_VSSW = 2, B_MSW = 3;
  localparam int unsigned B_STM = 5, B_VSTM = 6, B_MTM = 7;
  localparam int unsigned B_SEX = 9, B_VSEX = 10, B_MEX = 11;

  function automatic logic [31:0] bits3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
    return (32'd1 << a) | (32'd1 << b) | (32'd1 << c);
  endfunction

  localparam logic [31:0] SUP_BITS = bits3(B_SSW, B_STM, B_SEX);
  localparam logic [31:0] VS_BITS  = bits3(B_VSSW, B_VSTM, B_VSEX);
  localparam logic [31:0] MAC_BITS = bits3(B_MSW, B_MTM, B_MEX);
  localparam logic [31:0] ALL_BITS = SUP_BITS | VS_BITS | MAC_BITS;
  localparam logic [31:0] HW_BITS  = MAC_BITS | (32'd1 << B_SEX) | (32'd1 << B_VSEX);
  localparam logic [31:0] MPW_BITS = SUP_BITS | (32'd1 << B_VSSW);
  localparam logic [31:0] SSW_BIT  = 32'd1 << B_SSW;
  localparam logic [31:0] VSSW_BIT = 32'd1 << B_VSSW;

  localparam logic [ADDR_W-1:0] A_MPEND = 12'h344, A_MEN = 12'h304, A_MDEL = 12'h303;
  localparam logic [ADDR_W-1:0] A_SPEND = 12'h144, A_SEN = 12'h104;
  localparam logic [ADDR_W-1:0] A_HPEND = 12'h644, A_HEN = 12'h604, A_HVIRT = 12'h645;
  localparam logic [ADDR_W-1:0] A_HDEL  = 12'h603, A_GPEND = 12'h244, A_GEN = 12'h204;

  typedef enum logic [3:0] {
    VW_NONE, VW_MPEND, VW_MEN, VW_MDEL, VW_SPEND, VW_SEN,
    VW_HPEND, VW_HEN, VW_HVIRT, VW_HDEL, VW_GPEND, VW_GEN
  } view_e;

  typedef enum logic [2:0] {TG_NONE, TG_PEND, TG_EN, TG_MDEL, TG_HDEL} tgt_e;

  function automatic view_e addr_to_view(input logic [ADDR_W-1:0] a);
    case (a)
      A_MPEND: return VW_MPEND;
      A_MEN:   return VW_MEN;
      A_MDEL:  return VW_MDEL;
      A_SPEND: return VW_SPEND;
      A_SEN:   return VW_SEN;
      A_HPEND: return VW_HPEND;
      A_HEN:   return VW_HEN;
      A_HVIRT: return VW_HVIRT;
      A_HDEL:  return VW_HDEL;
      A_GPEND: return VW_GPEND;
      A_GEN:   return VW_GEN;
      default: return VW_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ipv_access_decode.sv
`timescale 1ns/1ps
// Privilege check and guest redirection; yields the selected view or none.
module ipv_access_decode
  import ipv_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        priv,
  input  logic              virt,
  output view_e             view
);
  logic              is_m;
  logic              ok;
  logic [ADDR_W-1:0] eff;

  always_comb begin
    is_m = (priv == 2'd3);
    eff  = addr;
    ok   = 1'b0;
    case (addr[9:8])
      2'd3: ok = is_m;
      2'd2: ok = is_m || (priv == 2'd1 && !virt);
      2'd1: begin
        ok = is_m || (priv == 2'd1);
        // a virtualized supervisor lands on the guest register
        if (virt && !is_m) eff = addr ^ 12'h300;
      end
      default: ok = 1'b0;
    endcase
    view = ok ? addr_to_view(eff) : VW_NONE;
  end
endmodule

// File: rtl/ipv_deleg_regs.sv
`timescale 1ns/1ps
// Both delegation registers with their fixed-one and fixed-zero bits.
module ipv_deleg_regs
  import ipv_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_m,
  input  logic          we_h,
  input  logic [DW-1:0] wr_mask,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] mdel_val,
  output logic [DW-1:0] hdel_val
);
  localparam logic [DW-1:0] MD_WR  = DW'(SUP_BITS);
  localparam logic [DW-1:0] MD_ONE = DW'(VS_BITS);
  localparam logic [DW-1:0] HD_WR  = DW'(VS_BITS);

  logic [DW-1:0] md_q, hd_q;
  logic [DW-1:0] md_m, hd_m;

  assign md_m = wr_mask & MD_WR;
  assign hd_m = wr_mask & HD_WR;

  always_ff @(posedge clk) begin
    if (rst) begin
      md_q <= '0;
      hd_q <= '0;
    end else begin
      if (we_m) md_q <= (md_q & ~md_m) | (wr_data & md_m);
      if (we_h) hd_q <= (hd_q & ~hd_m) | (wr_data & hd_m);
    end
  end

  assign mdel_val = (md_q & MD_WR) | MD_ONE;
  assign hdel_val = hd_q & HD_WR;
endmodule

// File: rtl/ipv_bit_store.sv
`timescale 1ns/1ps
// The single physical copy of software pending bits and enable bits.
module ipv_bit_store
  import ipv_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_pend,
  input  logic          we_en,
  input  logic [DW-1:0] wr_mask,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] pend_sw,
  output logic [DW-1:0] en_val
);
  localparam logic [DW-1:0] PD_WR = DW'(SUP_BITS | VS_BITS);
  localparam logic [DW-1:0] EN_WR = DW'(ALL_BITS);

  logic [DW-1:0] pd_q, en_q;
  logic [DW-1:0] pd_m, en_m;

  assign pd_m = wr_mask & PD_WR;
  assign en_m = wr_mask & EN_WR;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q <= '0;
      en_q <= '0;
    end else begin
      if (we_pend) pd_q <= (pd_q & ~pd_m) | (wr_data & pd_m);
      if (we_en)   en_q <= (en_q & ~en_m) | (wr_data & en_m);
    end
  end

  assign pend_sw = pd_q & PD_WR;
  assign en_val  = en_q & EN_WR;
endmodule

// File: rtl/ipv_view_map.sv
`timescale 1ns/1ps
// Per-view read masking/shifting and write target, mask and alignment.
module ipv_view_map
  import ipv_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  view_e         view,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pend_val,
  input  logic [DW-1:0] pend_sw,
  input  logic [DW-1:0] en_val,
  input  logic [DW-1:0] mdel_val,
  input  logic [DW-1:0] hdel_val,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] wr_mask,
  output logic [DW-1:0] wr_data,
  output tgt_e          wr_tgt
);
  localparam logic [DW-1:0] M_ALL  = DW'(ALL_BITS);
  localparam logic [DW-1:0] M_VS   = DW'(VS_BITS);
  localparam logic [DW-1:0] M_SV   = DW'(SUP_BITS | VS_BITS);
  localparam logic [DW-1:0] M_MPW  = DW'(MPW_BITS);
  localparam logic [DW-1:0] M_SSW  = DW'(SSW_BIT);
  localparam logic [DW-1:0] M_VSSW = DW'(VSSW_BIT);

  always_comb begin
    rd_val  = '0;
    wr_mask = '0;
    wr_data = wdata;
    wr_tgt  = TG_NONE;
    case (view)
      VW_MPEND: begin rd_val = pend_val & M_ALL; wr_tgt = TG_PEND; wr_mask = M_MPW; end
      VW_MEN:   begin rd_val = en_val & M_ALL;   wr_tgt = TG_EN;   wr_mask = M_ALL; end
      VW_MDEL:  begin rd_val = mdel_val;         wr_tgt = TG_MDEL; wr_mask = '1;    end
      VW_HDEL:  begin rd_val = hdel_val;         wr_tgt = TG_HDEL; wr_mask = '1;    end
      VW_SPEND: begin
        rd_val  = pend_val & mdel_val & M_SV;
        wr_tgt  = TG_PEND;
        wr_mask = mdel_val & M_SSW;
      end
      VW_SEN: begin
        rd_val  = en_val & mdel_val & M_SV;
        wr_tgt  = TG_EN;
        wr_mask = mdel_val & M_SV;
      end
      VW_HPEND: begin rd_val = pend_val & M_VS; wr_tgt = TG_PEND; wr_mask = M_VSSW; end
      VW_HEN:   begin rd_val = en_val & M_VS;   wr_tgt = TG_EN;   wr_mask = M_VS;   end
      VW_HVIRT: begin rd_val = pend_sw & M_VS;  wr_tgt = TG_PEND; wr_mask = M_VS;   end
      VW_GPEND: begin
        rd_val  = (pend_val & hdel_val & M_VS) >> 1;
        wr_tgt  = TG_PEND;
        wr_mask = hdel_val & M_VSSW;
        wr_data = wdata << 1;
      end
      VW_GEN: begin
        rd_val  = (en_val & hdel_val & M_VS) >> 1;
        wr_tgt  = TG_EN;
        wr_mask = hdel_val & M_VS;
        wr_data = wdata << 1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/intr_view_csr.sv
`timescale 1ns/1ps
// Top: one pending/enable store exposed through delegated CSR windows.
module intr_view_csr
  import ipv_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DW-1:0]     csr_wdata,
  input  logic [1:0]        csr_priv,
  input  logic              csr_virt,
  input  logic [DW-1:0]     hw_irq,
  output logic [DW-1:0]     csr_rdata,
  output logic [DW-1:0]     m_irq,
  output logic [DW-1:0]     s_irq,
  output logic [DW-1:0]     vs_irq
);
  localparam logic [DW-1:0] M_HW  = DW'(HW_BITS);
  localparam logic [DW-1:0] M_ALL = DW'(ALL_BITS);
  localparam logic [DW-1:0] M_VS  = DW'(VS_BITS);

  view_e         view_dec, view;
  tgt_e          wr_tgt;
  logic          wr_go;
  logic [DW-1:0] rd_val, wr_mask, wr_data;
  logic [DW-1:0] pend_sw, pend_val, en_val, mdel_val, hdel_val, active;

  ipv_access_decode u_dec (
    .addr (csr_addr),
    .priv (csr_priv),
    .virt (csr_virt),
    .view (view_dec)
  );

  assign view  = csr_en ? view_dec : VW_NONE;
  assign wr_go = csr_en & csr_we;

  ipv_view_map #(.DW(DW)) u_map (
    .view     (view),
    .wdata    (csr_wdata),
    .pend_val (pend_val),
    .pend_sw  (pend_sw),
    .en_val   (en_val),
    .mdel_val (mdel_val),
    .hdel_val (hdel_val),
    .rd_val   (rd_val),
    .wr_mask  (wr_mask),
    .wr_data  (wr_data),
    .wr_tgt   (wr_tgt)
  );

  ipv_bit_store #(.DW(DW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we_pend (wr_go && wr_tgt == TG_PEND),
    .we_en   (wr_go && wr_tgt == TG_EN),
    .wr_mask (wr_mask),
    .wr_data (wr_data),
    .pend_sw (pend_sw),
    .en_val  (en_val)
  );

  ipv_deleg_regs #(.DW(DW)) u_deleg (
    .clk      (clk),
    .rst      (rst),
    .we_m     (wr_go && wr_tgt == TG_MDEL),
    .we_h     (wr_go && wr_tgt == TG_HDEL),
    .wr_mask  (wr_mask),
    .wr_data  (wr_data),
    .mdel_val (mdel_val),
    .hdel_val (hdel_val)
  );

  assign pend_val = pend_sw | (hw_irq & M_HW);
  assign active   = pend_val & en_val & M_ALL;

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
      m_irq     <= '0;
      s_irq     <= '0;
      vs_irq    <= '0;
    end else begin
      csr_rdata <= rd_val;
      m_irq     <= active & ~mdel_val;
      s_irq     <= active & mdel_val & ~hdel_val;
      vs_irq    <= (active & hdel_val & M_VS) >> 1;
    end
  end
endmodule

// File: rtl/intr_view_csr_chk.sv
`timescale 1ns/1ps
module intr_view_csr_chk
  import ipv_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_en,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [1:0]        csr_priv,
  input logic [DW-1:0]     csr_rdata,
  input logic [DW-1:0]     m_irq,
  input logic [DW-1:0]     s_irq,
  input logic [DW-1:0]     vs_irq
);
  localparam logic [DW-1:0] C_VS  = DW'(VS_BITS);
  localparam logic [DW-1:0] C_SUP = DW'(SUP_BITS);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (csr_rdata == '0 && m_irq == '0 && s_irq == '0 && vs_irq == '0));

  // R2
  mdel_warl_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_priv == 2'd3 && csr_addr == A_MDEL)
      |=> ((csr_rdata & C_VS) == C_VS && (csr_rdata & ~(C_VS | C_SUP)) == '0));

  // R3
  hdel_warl_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_priv == 2'd3 && csr_addr == A_HDEL) |=> ((csr_rdata & ~C_VS) == '0));

  // R10
  user_denied_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_priv == 2'd0) |=> (csr_rdata == '0));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !csr_en |=> (csr_rdata == '0));

  // R13
  unknown_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_addr[7:0] == 8'hFF) |=> (csr_rdata == '0));

  // R12
  level_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    (m_irq & s_irq) == '0);

  // R7
  guest_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (vs_irq & ~C_SUP) == '0);
endmodule

bind intr_view_csr intr_view_csr_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .csr_en    (csr_en),
  .csr_addr  (csr_addr),
  .csr_priv  (csr_priv),
  .csr_rdata (csr_rdata),
  .m_irq     (m_irq),
  .s_irq     (s_irq),
  .vs_irq    (vs_irq)
);

// File: tb/intr_view_csr_tb_top.sv
`timescale 1ns/1ps
module intr_view_csr_tb_top;
  localparam int unsigned DW = 16;
  localparam logic [1:0] PM = 2'd3, PS = 2'd1, PU = 2'd0;
  localparam logic [11:0] MP = 12'h344, ME = 12'h304, MD = 12'h303, SPV = 12'h144,
                          SE = 12'h104, HP = 12'h644, HV = 12'h645, HD = 12'h603,
                          GP = 12'h244, GE = 12'h204;

  logic clk = 1'b0, rst = 1'b1;
  logic csr_en = 1'b0, csr_we = 1'b0, csr_virt = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [DW-1:0] csr_wdata = '0, hw_irq = '0;
  logic [1:0] csr_priv = 2'd3;
  logic [DW-1:0] csr_rdata, m_irq, s_irq, vs_irq;

  int total = 0, bad = 0;
  int unsigned cyc = 0;

  typedef struct {
    logic [DW-1:0] exp;
    int unsigned   due;
    string         tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;  // 200 MHz
  always @(posedge clk) cyc <= cyc + 1;

  intr_view_csr #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_priv(csr_priv), .csr_virt(csr_virt), .hw_irq(hw_irq),
    .csr_rdata(csr_rdata), .m_irq(m_irq), .s_irq(s_irq), .vs_irq(vs_irq)
  );

  // driver: one access, expected read data queued for the next cycle
  task automatic acc(input logic [11:0] a, input logic we, input logic [DW-1:0] d,
                     input logic [1:0] p, input logic v, input logic [DW-1:0] e,
                     input string tag);
    item_t it;
    @(negedge clk);
    csr_en = 1'b1; csr_we = we; csr_addr = a; csr_wdata = d; csr_priv = p; csr_virt = v;
    it.exp = e; it.due = cyc + 1; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [DW-1:0] e, input string tag);
    acc(a, 1'b0, '0, PM, 1'b0, e, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [DW-1:0] d);
    acc(a, 1'b1, d, PM, 1'b0, 'x, "");
  endtask

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] e, input string tag);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  // monitor: pops each expectation in the cycle its read data is due
  initial forever begin
    @(negedge clk);
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.tag != "") chk(csr_rdata, it.exp, it.tag);
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1
    chk(csr_rdata, '0, "R1 rdata"); chk(m_irq, '0, "R1 m_irq");
    chk(s_irq, '0, "R1 s_irq");     chk(vs_irq, '0, "R1 vs_irq");
    rd(MP, 16'h0000, "R1 mpend"); rd(ME, 16'h0000, "R1 men");
    rd(MD, 16'h0444, "R1 mdel");  rd(HD, 16'h0000, "R1 hdel");
    // R2 / R11 (write returns prior value)
    acc(MD, 1'b1, 16'hFFFF, PM, 1'b0, 16'h0444, "R11 old value on write");
    rd(MD, 16'h0666, "R2 mdel all ones");
    acc(MD, 1'b1, 16'h0000, PM, 1'b0, 16'h0666, "R11 old value on write 2");
    rd(MD, 16'h0444, "R2 mdel zero");
    // R3
    wr(HD, 16'hFFFF); rd(HD, 16'h0444, "R3 hdel mask");
    // R4
    wr(MP, 16'hFFFF); rd(MP, 16'h0226, "R4 writable bits");
    hw_irq = 16'hFFFF;
    rd(MP, 16'h0EAE, "R4 hw lines merged");
    wr(MP, 16'h0000); rd(MP, 16'h0E88, "R4 hw bits not clearable");
    hw_irq = 16'h0000;
    // R5
    wr(MP, 16'h0222); rd(SPV, 16'h0000, "R5 hidden when undelegated");
    wr(MD, 16'h0222); rd(SPV, 16'h0222, "R5 delegated visible");
    acc(SPV, 1'b1, 16'h0000, PS, 1'b0, 'x, "");
    rd(SPV, 16'h0220, "R5 only software bit cleared");
    acc(SPV, 1'b1, 16'hFFFF, PS, 1'b0, 'x, "");
    rd(SPV, 16'h0222, "R5 timer read-only");
    wr(MP, 16'h0000);
    // R6
    wr(HV, 16'hFFFF); rd(HV, 16'h0444, "R6 injection reg");
    rd(MP, 16'h0444, "R6 machine alias"); rd(HP, 16'h0444, "R6 hyp alias");
    wr(HV, 16'h0000); rd(MP, 16'h0000, "R6 cleared");
    // R7 / R8 / R10 redirect (hdel = 0x0444)
    wr(HV, 16'h0444);
    acc(GP, 1'b0, '0, PS, 1'b0, 16'h0222, "R7 guest shift");
    acc(SPV, 1'b0, '0, PS, 1'b1, 16'h0222, "R10 virt redirect");
    wr(HD, 16'h0004); rd(GP, 16'h0002, "R7 partial delegation");
    wr(GP, 16'hFFFF); rd(HV, 16'h0444, "R7 undelegated writes ignored");
    wr(GP, 16'h0000); rd(HV, 16'h0440, "R8 guest write clears bit 2");
    rd(MP, 16'h0440, "R8 machine alias");
    wr(GP, 16'h0002); rd(MP, 16'h0444, "R8 guest write sets bit 2");
    wr(HD, 16'h0000); wr(GP, 16'h0000);
    rd(HV, 16'h0444, "R7 dark guest ignores write"); rd(GP, 16'h0000, "R7 dark guest reads zero");
    // R9
    wr(ME, 16'hFFFF); rd(ME, 16'h0EEE, "R9 machine enable");
    wr(HD, 16'h0040); rd(GE, 16'h0020, "R9 guest enable shift");
    wr(GE, 16'h0000); rd(ME, 16'h0EAE, "R9 guest enable write");
    wr(MD, 16'h0000); rd(SE, 16'h0404, "R9 sup enable mask");
    acc(SE, 1'b1, 16'h0000, PS, 1'b0, 'x, "");
    rd(ME, 16'h0AAA, "R9 sup enable write");
    // R10
    acc(MP, 1'b0, '0, PU, 1'b0, 16'h0000, "R10 user read");
    acc(MP, 1'b1, 16'hFFFF, PS, 1'b0, 16'h0000, "R10 sup to machine");
    rd(MP, 16'h0444, "R10 write ignored");
    acc(HV, 1'b0, '0, PS, 1'b1, 16'h0000, "R10 virt to hyp");
    // R12
    wr(ME, 16'h0EEE); wr(MD, 16'h0000); wr(HD, 16'h0400);
    hw_irq = 16'h0088;
    wr(MP, 16'h0002); wr(HV, 16'h0444);
    @(negedge clk);
    chk(m_irq, 16'h008A, "R12 machine vector");
    chk(s_irq, 16'h0044, "R12 supervisor vector");
    chk(vs_irq, 16'h0200, "R12 guest vector");
    wr(ME, 16'h0000);
    @(negedge clk);
    chk(m_irq | s_irq | vs_irq, 16'h0000, "R12 enable gating");
    hw_irq = 16'h0000;
    // R13
    rd(12'h7FF, 16'h0000, "R13 unknown addr"); rd(12'h345, 16'h0000, "R13 neighbour addr");
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule